// File: doc/BRIEF.md
# HDB3 Receive Line Decoder with Violation Counter

This block sits at the receive line side of a framer. Each bit period is marked by a one-cycle enable on the system clock. In rail mode it takes the positive and negative pulse rails of a bipolar line signal. It strips the HDB3 zero substitutions (000V and B00V), rebuilds the NRZ bit stream and flags every rail pattern that no legal substitution explains. In NRZ mode the single data input passes straight through. In that mode nothing is decoded and no violation is counted.

Each violation raises a one-cycle pulse. The same event also steps an 8-bit counter, which stops at its maximum value. Software reads the counter and then pulses a synchronous clear. Rail data passes through a four-symbol window so that a complete substitution group can be replaced by zeros before any of its bits leave the block.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: After rst_ni is asserted, data_o, valid_o and viol_o are 0 and viol_cnt_o is 0.
- R2: With nrz_mode_i=1, on each enabled cycle data_o takes the nrz_i value one clock later. The rail inputs have no effect, viol_o stays 0 and the counter does not change.
- R3: With nrz_mode_i=0, a symbol of pos_i=1, neg_i=0 or pos_i=0, neg_i=1 is a mark and decodes to 1. pos_i=neg_i=0 decodes to 0. The decoded bit appears on data_o four enabled cycles after its symbol, and the first four outputs after reset are 0.
- R4: A mark with the same polarity as the previous mark, preceded by at least three zero symbols (000V), decodes as four zeros and raises no violation.
- R5: A mark with the same polarity as the previous mark, where the two symbols before it are zeros and the symbol before those is a mark (B00V), decodes as four zeros and raises no violation.
- R6: A mark with the same polarity as the previous mark, where either of the two symbols just before it is a mark, raises viol_o for exactly one cycle, one clock after its enable, and decodes to 1. The first mark after reset is never a violation.
- R7: A symbol with pos_i=neg_i=1 in rail mode raises viol_o, decodes to 0 and does not change the remembered polarity.
- R8: Each violation adds one to viol_cnt_o. The counter holds at 255 and does not wrap.
- R9: clr_i sets viol_cnt_o to 0 at the next clock. If a violation occurs in the same cycle, viol_cnt_o becomes 1.
- R10: When en_i=0, valid_o and viol_o are 0 at the next clock, and the decoding state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nrz_mode_i | input | 1 | Static: 1 selects NRZ pass-through, 0 selects rail decoding |
| en_i | input | 1 | One-cycle strobe per line bit |
| pos_i | input | 1 | Positive pulse rail |
| neg_i | input | 1 | Negative pulse rail |
| nrz_i | input | 1 | NRZ line data |
| clr_i | input | 1 | Synchronous clear of the violation counter |
| data_o | output | 1 | Recovered NRZ data |
| valid_o | output | 1 | data_o carries a new bit |
| viol_o | output | 1 | One-cycle coding violation pulse |
| viol_cnt_o | output | CNT_W | Saturating violation count |

## Verification
The checker covers the counter and the strobes on every cycle. It checks that the counter moves by at most one step, stops at its maximum, and clears to 0 or 1. It checks that NRZ mode and idle cycles yield no violation and no valid strobe, and that a both-rails symbol is always flagged. Only the bench's scenarios can show whether the substitution decoding is correct. That covers the 000V and B00V groups turning into zeros, the four-bit latency, and the split between a legal substitution and a same-polarity error. It depends on the ordered symbol history.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;
  localparam int unsigned SUB_LEN = 4;            // substitution group length
  localparam int unsigned ZERO_GAP = SUB_LEN - 2; // zeros required just before V

  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b10,
    SYM_BAD  = 2'b11
  } line_sym_e;
endpackage

// File: rtl/hdb3_sym_classify.sv
module hdb3_sym_classify
  import hdb3_rx_pkg::*;
(
  input  logic      pos_i,
  input  logic      neg_i,
  output line_sym_e sym_o,
  output logic      mark_o,
  output logic      neg_pol_o
);
  always_comb begin
    sym_o     = line_sym_e'({neg_i, pos_i});
    mark_o    = (sym_o == SYM_POS) || (sym_o == SYM_NEG);
    neg_pol_o = (sym_o == SYM_NEG);
  end
endmodule

// File: rtl/hdb3_subst_pipe.sv
module hdb3_subst_pipe
  import hdb3_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  line_sym_e sym_i,
  input  logic      mark_i,
  input  logic      neg_pol_i,
  output logic      bit_o,
  output logic      viol_o
);
  logic [SUB_LEN-1:0]  win_q;   // decoded bits, [0] newest
  logic [ZERO_GAP-1:0] hist_q;  // raw marks of last symbols
  logic                seen_q;
  logic                pol_q;

  logic same_pol, legal_sub;

  always_comb begin
    same_pol  = mark_i && seen_q && (neg_pol_i == pol_q);
    legal_sub = same_pol && (hist_q == '0);
    viol_o    = (same_pol && !legal_sub) || (sym_i == SYM_BAD);
    bit_o     = win_q[SUB_LEN-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      hist_q <= '0;
      seen_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (step_i) begin
      if (legal_sub) win_q <= '0;
      else           win_q <= {win_q[SUB_LEN-2:0], mark_i};
      hist_q <= {hist_q[ZERO_GAP-2:0], mark_i};
      if (mark_i) begin
        seen_q <= 1'b1;
        pol_q  <= neg_pol_i;
      end
    end
  end
endmodule

// File: rtl/viol_sat_counter.sv
module viol_sat_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nrz_mode_i,
  input  logic             en_i,
  input  logic             pos_i,
  input  logic             neg_i,
  input  logic             nrz_i,
  input  logic             clr_i,
  output logic             data_o,
  output logic             valid_o,
  output logic             viol_o,
  output logic [CNT_W-1:0] viol_cnt_o
);
  line_sym_e sym;
  logic      mark, neg_pol, rail_bit, rail_viol, rail_step, viol_evt;

  hdb3_sym_classify u_cls (
    .pos_i     (pos_i),
    .neg_i     (neg_i),
    .sym_o     (sym),
    .mark_o    (mark),
    .neg_pol_o (neg_pol)
  );

  assign rail_step = en_i && !nrz_mode_i;
  assign viol_evt  = rail_step && rail_viol;

  hdb3_subst_pipe u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (rail_step),
    .sym_i     (sym),
    .mark_i    (mark),
    .neg_pol_i (neg_pol),
    .bit_o     (rail_bit),
    .viol_o    (rail_viol)
  );

  viol_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .inc_i  (viol_evt),
    .cnt_o  (viol_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= 1'b0;
      valid_o <= 1'b0;
      viol_o  <= 1'b0;
    end else begin
      valid_o <= en_i;
      viol_o  <= viol_evt;
      if (en_i) data_o <= nrz_mode_i ? nrz_i : rail_bit;
    end
  end
endmodule

// File: rtl/hdb3_rx_decoder_sva.sv
module hdb3_rx_decoder_sva #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             nrz_mode_i,
  input logic             en_i,
  input logic             pos_i,
  input logic             neg_i,
  input logic             clr_i,
  input logic             valid_o,
  input logic             viol_o,
  input logic [CNT_W-1:0] viol_cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_cnt_o == CMAX && !clr_i) |=> viol_cnt_o == CMAX);

  a_r8_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (viol_cnt_o == $past(viol_cnt_o) ||
                viol_cnt_o == $past(viol_cnt_o) + CNT_W'(1)));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> viol_cnt_o <= CNT_W'(1));

  a_r2_nrz_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrz_mode_i && !clr_i) |=> (!viol_o && $stable(viol_cnt_o)));

  a_r7_both_rails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nrz_mode_i && en_i && pos_i && neg_i) |=> viol_o);

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!valid_o && !viol_o));

  a_r6_pulse_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> valid_o);
endmodule

bind hdb3_rx_decoder hdb3_rx_decoder_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nrz_mode_i (nrz_mode_i),
  .en_i       (en_i),
  .pos_i      (pos_i),
  .neg_i      (neg_i),
  .clr_i      (clr_i),
  .valid_o    (valid_o),
  .viol_o     (viol_o),
  .viol_cnt_o (viol_cnt_o)
);

// File: tb/hdb3_rx_decoder_test.sv
module hdb3_rx_decoder_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       nrz_mode_i = 1'b0;
  logic       en_i = 1'b0;
  logic       pos_i = 1'b0;
  logic       neg_i = 1'b0;
  logic       nrz_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       data_o, valid_o, viol_o;
  logic [7:0] viol_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  hdb3_rx_decoder uut (.*);

  // {pos, neg, final decoded bit, violation expected}
  localparam int NV = 30;
  localparam logic [3:0] VEC [NV] = '{
    4'b1010, 4'b0000, 4'b0110, 4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b1000,
    4'b0110, 4'b1010, 4'b0100, 4'b0000, 4'b0000, 4'b0100, 4'b1010, 4'b1011,
    4'b1101, 4'b0110, 4'b0000, 4'b0111, 4'b1010, 4'b0000, 4'b0000, 4'b0000,
    4'b0000, 4'b0110, 4'b0000, 4'b0000, 4'b0000, 4'b0000
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic n, input logic nz,
                      input logic e, input logic c);
    pos_i = p; neg_i = n; nrz_i = nz; en_i = e; clr_i = c;
    @(posedge clk_i);
    @(negedge clk_i);
    en_i = 1'b0; clr_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 data", int'(data_o), 0);
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 viol", int'(viol_o), 0);
    chk("R1 count", int'(viol_cnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R4 R5 R6 R7: rail table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][3], VEC[i][2], 1'b0, 1'b1, 1'b0);
      chk("R3 valid", int'(valid_o), 1);
      chk($sformatf("R3/R4/R5 data step %0d", i), int'(data_o),
          (i >= 4) ? int'(VEC[i-4][1]) : 0);
      chk($sformatf("R6/R7 viol step %0d", i), int'(viol_o), int'(VEC[i][0]));
    end
    chk("R8 count after table", int'(viol_cnt_o), 3);

    // R10: idle enable
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10 valid idle", int'(valid_o), 0);
    chk("R10 viol idle", int'(viol_o), 0);
    chk("R10 count idle", int'(viol_cnt_o), 3);

    // R2: NRZ pass-through, rails ignored
    nrz_mode_i = 1'b1;
    @(negedge clk_i);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R2 data 1", int'(data_o), 1);
    chk("R2 valid", int'(valid_o), 1);
    chk("R2 viol", int'(viol_o), 0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R2 data 0", int'(data_o), 0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R2 data 1b", int'(data_o), 1);
    chk("R2 count", int'(viol_cnt_o), 3);
    nrz_mode_i = 1'b0;
    @(negedge clk_i);

    // R8: saturation
    for (int k = 0; k < 252; k++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R8 reach max", int'(viol_cnt_o), 255);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R8 hold max", int'(viol_cnt_o), 255);
    chk("R7 viol at max", int'(viol_o), 1);

    // R9: clear, then clear with coincident violation
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 clear", int'(viol_cnt_o), 0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R8 increment", int'(viol_cnt_o), 1);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R9 clear with violation", int'(viol_cnt_o), 1);

    // R1: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 count after reset", int'(viol_cnt_o), 0);
    chk("R1 valid after reset", int'(valid_o), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule